// File: doc/BRIEF.md
# Integer to Real and Real to Integer Converter

This block converts between two's-complement integers and a two-word real format. Each 16-bit word of the real is stored with its most significant bit first. Bit 15 of the high word is the sign. Bits 14:6 hold a 9-bit exponent with a bias of 256. The remaining 22 bits hold the fraction: high-word bits 5:0 followed by all 16 bits of the low word. The value is 1.fraction × 2^(exponent−256). The all-zero pattern stands for zero.

In float mode, a 16-bit or 32-bit signed integer becomes a normalized, rounded real. In fix mode, a real becomes a 32-bit signed integer, either rounded to nearest (halves away from zero) or truncated toward zero. Fix mode reports an integer overflow through a trap code.

Operation timing:
- A request is presented with a one-cycle `start` pulse.
- The result words, the trap code and `done` appear on the next clock edge.
- The outputs then hold until the next request.

Top module: `int_real_conv`

## Requirements
- R1: With `op_fix`=0, a nonzero integer produces a real whose sign is the integer's sign, whose biased exponent (high word bits 14:6) is 256 plus the position of the magnitude's leading one, and whose 22-bit fraction holds the bits below that leading one. 16-bit integers convert exactly. Float mode never raises a trap (code 0).
- R2: With `wide_int`=1, a magnitude with more than 23 significant bits is rounded by adding one half of the fraction LSB. A carry from this rounding raises the exponent by one. Examples: 0x7FFFFFFF gives 0x47C0/0x0000, and 0x80000000 (−2^31) gives 0xC7C0/0x0000.
- R3: An integer zero floats to 0x0000/0x0000.
- R4: With `wide_int`=0, the integer is `in_hi` alone and `in_lo` has no effect on the result.
- R5: With `op_fix`=1, a real with a biased exponent below 255 (magnitude under one half) gives integer 0 with trap code 0.
- R6: With `round_en`=1, fix adds one half below the integer LSB of the magnitude before it discards the fraction. With `round_en`=0 it truncates. Expected results: 0.5 gives 1 rounded and 0 truncated; 1.5 gives 2 and 1; −1.5 gives −2 and −1.
- R7: The fix result is the two's-complement integer, with bits 31:16 on `out_hi` and bits 15:0 on `out_lo`. A negative real produces the negated magnitude.
- R8: A real with a biased exponent of 287 or more, including −2^31, fixes to 0 with trap code 1. A biased exponent of 286 converts normally.
- R9: A real with zero exponent and zero fraction but the sign set (negative zero) fixes to 0 with trap code 0.
- R10: Reset clears the outputs and `done`. The result and `done`=1 appear one clock after `start`. Without `start`, `done` is 0 and the result words keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe |
| op_fix | input | 1 | 0: integer to real, 1: real to integer |
| wide_int | input | 1 | Float mode: 1 takes a 32-bit integer, 0 takes 16 bits from `in_hi` |
| round_en | input | 1 | Fix mode: 1 rounds, 0 truncates |
| in_hi | input | 16 | High operand word |
| in_lo | input | 16 | Low operand word |
| out_hi | output | 16 | High result word |
| out_lo | output | 16 | Low result word |
| trap_code | output | TRAP_W | 0 none, 1 integer overflow |
| done | output | 1 | Result valid, one cycle after `start` |

## Verification
Every result is produced from one combinational pass that is registered in a single stage. A wrong leading-one position, rounding carry or shift amount therefore appears in the very next result. It shows as a shifted exponent field, a fraction off by one LSB, or an integer that is doubled or halved. The float sweep covers every 16-bit integer, so a fault in sign handling or normalization surfaces at the first affected value. Fix mode is swept across biased exponents from 250 to 290 in both rounding modes. This exposes an off-by-one in the one-half or overflow thresholds at the exact exponent where the result or trap changes.

// File: rtl/int_real_conv.sv
`timescale 1ns/1ps
module int_real_conv #(
  parameter int TRAP_W = 4,
  parameter logic [TRAP_W-1:0] OVF_CODE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_fix,
  input  logic              wide_int,
  input  logic              round_en,
  input  logic [15:0]       in_hi,
  input  logic [15:0]       in_lo,
  output logic [15:0]       out_hi,
  output logic [15:0]       out_lo,
  output logic [TRAP_W-1:0] trap_code,
  output logic              done
);
  localparam logic [8:0] BIAS     = 9'd256;
  localparam logic [8:0] HALF_EXP = BIAS - 9'd1;
  localparam logic [8:0] OVF_EXP  = BIAS + 9'd31;

  // integer -> real
  logic [31:0] ival, imag, norm;
  logic        ineg;
  logic [4:0]  lead;
  logic [23:0] rsum;
  logic [8:0]  fexp;
  logic [31:0] fword;

  assign ival = wide_int ? {in_hi, in_lo} : {{16{in_hi[15]}}, in_hi};
  assign ineg = ival[31];
  assign imag = ineg ? (~ival + 32'd1) : ival;

  always_comb begin
    lead = '0;
    for (int i = 0; i < 32; i++)
      if (imag[i]) lead = 5'(i);
  end

  assign norm  = imag << (5'd31 - lead);
  assign rsum  = {2'b01, norm[30:9]} + {23'd0, norm[8]};
  assign fexp  = BIAS + {4'd0, lead} + {8'd0, rsum[23]};
  assign fword = (imag == '0) ? 32'd0 : {ineg, fexp, rsum[21:0]};

  // real -> integer
  logic [8:0]  rexp, sh;
  logic [21:0] rfrac;
  logic        rzero, rsmall, rovf;
  logic [54:0] wide;
  logic [32:0] twice, mag;
  logic [31:0] xword;

  assign rexp   = in_hi[14:6];
  assign rfrac  = {in_hi[5:0], in_lo};
  assign rzero  = (rexp == '0) && (rfrac == '0);
  assign rovf   = !rzero && (rexp >= OVF_EXP);
  assign rsmall = rzero || (rexp < HALF_EXP);
  assign sh     = rexp - HALF_EXP;
  assign wide   = {32'd0, 1'b1, rfrac} << sh[4:0];
  assign twice  = wide[54:22];
  assign mag    = round_en ? ((twice + 33'd1) >> 1) : (twice >> 1);
  assign xword  = (rsmall || rovf) ? 32'd0 :
                  (in_hi[15] ? (~mag[31:0] + 32'd1) : mag[31:0]);

  logic unused_bits;
  assign unused_bits = ^{norm[7:0], rsum[22], wide[21:0], mag[32]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_hi    <= '0;
      out_lo    <= '0;
      trap_code <= '0;
      done      <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        {out_hi, out_lo} <= op_fix ? xword : fword;
        trap_code        <= (op_fix && rovf) ? OVF_CODE : '0;
      end
    end
  end
endmodule

module int_real_conv_chk #(parameter int TRAP_W = 4) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              op_fix,
  input logic              wide_int,
  input logic [15:0]       in_hi,
  input logic [15:0]       in_lo,
  input logic [15:0]       out_hi,
  input logic [15:0]       out_lo,
  input logic [TRAP_W-1:0] trap_code,
  input logic              done
);
  logic int_zero;
  assign int_zero = (in_hi == 16'd0) && (!wide_int || in_lo == 16'd0);

  a_r1_float_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    start && !op_fix |=> trap_code == '0);

  a_r1_float_exp_range: assert property (@(posedge clk) disable iff (!rst_n)
    start && !op_fix && !int_zero |=> out_hi[14:6] >= 9'd256 && out_hi[14:6] <= 9'd287);

  a_r3_zero_float: assert property (@(posedge clk) disable iff (!rst_n)
    start && !op_fix && int_zero |=> out_hi == 16'd0 && out_lo == 16'd0);

  a_r5_small_real: assert property (@(posedge clk) disable iff (!rst_n)
    start && op_fix && in_hi[14:6] < 9'd255 |=> out_hi == 16'd0 && out_lo == 16'd0 && trap_code == '0);

  a_r7_neg_sign: assert property (@(posedge clk) disable iff (!rst_n)
    start && op_fix && in_hi[15] && in_hi[14:6] >= 9'd256 && in_hi[14:6] <= 9'd286 |=> out_hi[15]);

  a_r8_trap_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    done && trap_code != '0 |-> out_hi == 16'd0 && out_lo == 16'd0);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done && $stable(out_hi) && $stable(out_lo) && $stable(trap_code));
endmodule

bind int_real_conv int_real_conv_chk #(.TRAP_W(TRAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op_fix(op_fix), .wide_int(wide_int),
  .in_hi(in_hi), .in_lo(in_lo), .out_hi(out_hi), .out_lo(out_lo),
  .trap_code(trap_code), .done(done));

// File: tb/test_int_real_conv.sv
`timescale 1ns/1ps
module test_int_real_conv;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic op_fix = 1'b0, wide_int = 1'b0, round_en = 1'b0;
  logic [15:0] in_hi = '0, in_lo = '0;
  logic [15:0] out_hi, out_lo;
  logic [3:0]  trap_code;
  logic        done;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  int_real_conv i_int_real_conv (
    .clk(clk), .rst_n(rst_n), .start(start), .op_fix(op_fix), .wide_int(wide_int),
    .round_en(round_en), .in_hi(in_hi), .in_lo(in_lo), .out_hi(out_hi), .out_lo(out_lo),
    .trap_code(trap_code), .done(done));

  function automatic logic [31:0] mdl_float(longint v);
    longint m, t, r;
    int p;
    logic s;
    if (v == 0) return 32'd0;
    s = (v < 0);
    m = s ? -v : v;
    p = 0;
    while ((m >> (p + 1)) != 0) p++;
    t = (m << 23) >> p;
    r = (t + 1) >> 1;
    if (r >= (longint'(1) << 23)) begin p++; r = r >> 1; end
    return {s, 9'(p + 256), 22'(r)};
  endfunction

  function automatic logic [35:0] mdl_fix(logic [15:0] hi, logic [15:0] lo, logic rnd);
    int ef;
    longint f, q;
    ef = int'(hi[14:6]);
    f  = longint'({hi[5:0], lo});
    if (ef == 0 && f == 0) return 36'd0;
    if (ef >= 287) return {4'd1, 32'd0};
    if (ef < 255) return 36'd0;
    q = ((((longint'(1) << 22) + f) << (ef - 255)) + (rnd ? (longint'(1) << 22) : 0)) >> 23;
    if (hi[15]) q = -q;
    return {4'd0, 32'(q)};
  endfunction

  task automatic run(input logic fx, input logic wd, input logic rn,
                     input logic [15:0] h, input logic [15:0] l);
    op_fix = fx; wide_int = wd; round_en = rn; in_hi = h; in_lo = l; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] ev, input logic [3:0] et);
    n_cmp++;
    if ({out_hi, out_lo} !== ev || trap_code !== et || done !== 1'b1) begin
      n_bad++;
      $display("FAIL %s: got %h trap %0d done %b, expected %h trap %0d done 1",
               tag, {out_hi, out_lo}, trap_code, done, ev, et);
    end
  endtask

  task automatic do_float(input string tag, input logic wd, input logic [31:0] iv, input logic [15:0] lo_junk);
    longint v;
    v = wd ? longint'($signed(iv)) : longint'($signed(iv[31:16]));
    run(1'b0, wd, 1'b0, iv[31:16], wd ? iv[15:0] : lo_junk);
    chk(tag, mdl_float(v), 4'd0);
  endtask

  task automatic do_fix(input string tag, input logic rn, input logic [31:0] rv);
    logic [35:0] e;
    e = mdl_fix(rv[31:16], rv[15:0], rn);
    run(1'b1, 1'b0, rn, rv[31:16], rv[15:0]);
    chk(tag, e[31:0], e[35:32]);
  endtask

  initial begin
    #700000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] lcg;
    logic [31:0] fv;
    string tg;
    repeat (3) @(negedge clk);
    n_cmp++;
    if ({out_hi, out_lo} !== 32'd0 || trap_code !== 4'd0 || done !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 reset: got %h trap %0d done %b, expected 0 0 0", {out_hi, out_lo}, trap_code, done);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 R4: every 16-bit integer, junk in the low word
    for (int i = 0; i < 65536; i++)
      do_float("R1_R4_float16", 1'b0, {16'(i), 16'd0}, 16'(i * 37 + 5));

    // R10: hold and done timing
    do_float("R10_first", 1'b1, 32'd12345, 16'd0);
    in_hi = 16'hFFFF; in_lo = 16'hFFFF;
    @(negedge clk);
    n_cmp++;
    if (done !== 1'b0 || {out_hi, out_lo} !== mdl_float(12345)) begin
      n_bad++;
      $display("FAIL R10 hold: got %h done %b, expected %h done 0", {out_hi, out_lo}, done, mdl_float(12345));
    end

    // R2: 32-bit boundaries and rounding
    do_float("R2_max", 1'b1, 32'h7FFFFFFF, 16'd0);
    chk("R2_max_value", 32'h47C00000, 4'd0);
    do_float("R2_min", 1'b1, 32'h80000000, 16'd0);
    chk("R2_min_value", 32'hC7C00000, 4'd0);
    do_float("R3_zero32", 1'b1, 32'd0, 16'd0);
    chk("R3_zero_value", 32'd0, 4'd0);
    for (int k = 0; k < 31; k++) begin
      do_float("R2_pow", 1'b1, 32'd1 << k, 16'd0);
      do_float("R2_powm1", 1'b1, (32'd1 << k) - 32'd1, 16'd0);
      do_float("R2_negpow", 1'b1, -(32'd1 << k), 16'd0);
      do_float("R2_pow_half", 1'b1, (32'd1 << k) + ((32'd1 << k) >> 23), 16'd0);
    end
    lcg = 32'h1234_5678;
    for (int i = 0; i < 3000; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      do_float("R2_rand", 1'b1, lcg, 16'd0);
    end

    // R5 R6 R7 R8: exponent sweep around thresholds, both modes
    for (int ef = 250; ef <= 290; ef++)
      for (int p = 0; p < 5; p++)
        for (int s = 0; s < 2; s++)
          for (int r = 0; r < 2; r++) begin
            logic [21:0] fr;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            fr = (p == 0) ? 22'd0 : (p == 1) ? 22'h200000 : (p == 2) ? 22'h3FFFFF :
                 (p == 3) ? 22'h155555 : lcg[21:0];
            fv = {1'(s), 9'(ef), fr};
            tg = (ef < 255) ? "R5_small" : (ef >= 287) ? "R8_ovf" : (r == 1) ? "R6_R7_round" : "R6_R7_trunc";
            do_fix(tg, 1'(r), fv);
          end

    // R6 corner values
    do_fix("R6_half_round", 1'b1, {1'b0, 9'd255, 22'd0});
    chk("R6_half_round_value", 32'd1, 4'd0);
    do_fix("R6_half_trunc", 1'b0, {1'b0, 9'd255, 22'd0});
    chk("R6_half_trunc_value", 32'd0, 4'd0);
    do_fix("R6_1p5_round", 1'b1, {1'b0, 9'd256, 22'h200000});
    chk("R6_1p5_round_value", 32'd2, 4'd0);
    do_fix("R6_1p5_trunc", 1'b0, {1'b0, 9'd256, 22'h200000});
    chk("R6_1p5_trunc_value", 32'd1, 4'd0);
    do_fix("R6_m1p5_round", 1'b1, {1'b1, 9'd256, 22'h200000});
    chk("R6_m1p5_round_value", 32'hFFFFFFFE, 4'd0);
    do_fix("R7_m1p5_trunc", 1'b0, {1'b1, 9'd256, 22'h200000});
    chk("R7_m1p5_trunc_value", 32'hFFFFFFFF, 4'd0);
    do_fix("R5_below_half", 1'b1, {1'b0, 9'd254, 22'h3FFFFF});
    chk("R5_below_half_value", 32'd0, 4'd0);

    // R8 boundary
    do_fix("R8_exp30", 1'b1, {1'b0, 9'd286, 22'd0});
    chk("R8_exp30_value", 32'h40000000, 4'd0);
    do_fix("R8_exp31", 1'b0, {1'b0, 9'd287, 22'd0});
    chk("R8_exp31_value", 32'd0, 4'd1);
    do_fix("R8_minint", 1'b1, {1'b1, 9'd287, 22'd0});
    chk("R8_minint_value", 32'd0, 4'd1);

    // R9 negative zero
    do_fix("R9_negzero", 1'b1, 32'h80000000);
    chk("R9_negzero_value", 32'd0, 4'd0);

    // R1 R7 round trips of small integers
    for (int v = -300; v <= 300; v++) begin
      do_float("R1_trip", 1'b1, 32'(v), 16'd0);
      fv = {out_hi, out_lo};
      run(1'b1, 1'b0, v[0], fv[31:16], fv[15:0]);
      chk("R7_trip", 32'(v), 4'd0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule